// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Port

This block is a byte-wide serial port that a processor reaches through two register addresses. One address holds a control register, which is write-only, and a status register, which is read-only. The other address holds the transmit data register, which is write-only, and the receive data register, which is read-only. Software queues a byte by writing it. The transmitter sends the byte on `txd` with one start bit, eight data bits sent least significant bit first, and one stop bit. The receiver watches `rxd`, assembles incoming characters and holds the newest one until software reads it.

All timing comes from a prescaler. The prescaler divides the system clock by `CLK_DIV` to make a tick at the oversampling rate. One bit lasts `OVS` ticks, so one bit lasts `OVS*CLK_DIV` clock cycles. A single interrupt output combines a receive condition and a transmit condition, and each condition has its own enable. A special control code returns the whole port to its idle state without using the hardware reset.

The bus is a simple strobe interface. An access happens in each cycle where `acc_en` is high. `acc_rdata` is combinational and shows the register that `acc_addr` selects. Read side effects apply only when `acc_en` is high and `acc_wr` is low.

Top module: `serial_port_ctrl`

## Requirements
- R1: After hardware reset the status register reads 0x02, `txd` is high and `irq` is low.
- R2: A transmitted character is a low start bit, then 8 data bits with the least significant bit first, then a high stop bit. Each bit lasts OVS ticks. `txd` is high whenever no character is being sent.
- R3: Writing address 1 stores the byte and clears status bit 1. The transmitter takes the stored byte only when it is idle, and taking it sets status bit 1 again. A byte written while a frame is in progress waits in the register and follows that frame.
- R4: A falling edge on `rxd` starts reception only if `rxd` is still low half a bit time later. A low pulse shorter than that is ignored and produces no character.
- R5: When a character completes, status bit 0 is set. A read of address 1 returns the character and clears status bit 0.
- R6: If a character completes while status bit 0 is already set, status bit 5 (overrun) is set and the new character replaces the old one. A read of address 1 clears bit 5.
- R7: Every control write that is not a reset code loads the enables. Bit 7 enables the receive interrupt. The transmit interrupt is enabled only when bits [6:5] equal 01.
- R8: `irq` is high when (the receive interrupt is enabled and status bit 0, 2 or 5 is set) or (the transmit interrupt is enabled and status bit 1 is set). Status bit 7 always equals `irq`. Status bits 2 and 3, which are the modem lines, always read 0.
- R9: A control write with bits [1:0] = 11 is a master reset. In the next cycle `txd` is high and any frame in progress is abandoned. Both enables are cleared, overrun is cleared, and both data registers are empty: status reads 0x02 and receive data reads 0x00. `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on `clk` |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 1 | 0 = control/status, 1 = data |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for the selected register |
| rxd | input | 1 | Serial input, idle high |
| txd | output | 1 | Serial output, idle high |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench goes after the following corner cases:
- **Second character before the read.** If the overrun flag were not sticky, or were set on the wrong character, the status would read 0x03 instead of 0x23. If the receive register kept the old byte, the data read would return that older byte.
- **Second byte written while a frame is in progress.** The bench writes a second byte during an active frame. It expects status bit 1 to stay clear and the two frames to arrive in order. A transmitter that loaded from the register while busy would corrupt or drop the first frame.
- **Master reset.** The bench issues a master reset in the middle of a frame and while overrun and the interrupt are active. It expects `txd` to go high at once, `irq` to fall, and the receive data to read empty.
- **Short low glitch on `rxd`.** The glitch must leave status bit 0 clear. A receiver that did not confirm the start bit at mid-bit would report a character.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int SP_BYTE = 8;

  // status register bit positions
  localparam int ST_RXF = 0;
  localparam int ST_TXE = 1;
  localparam int ST_DCD = 2;
  localparam int ST_CTS = 3;
  localparam int ST_OVR = 5;
  localparam int ST_IRQ = 7;

  // control register fields
  localparam int CT_RIE = 7;
  localparam logic [1:0] CT_TXI_ON = 2'b01;
  localparam logic [1:0] CT_MRESET = 2'b11;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } sp_rx_st_e;
endpackage

// File: rtl/sp_tick_gen.sv
module sp_tick_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/sp_tx.sv
module sp_tx #(
  parameter int NBITS = 8,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             req,
  input  logic [NBITS-1:0] din,
  output logic             load,
  output logic             busy,
  output logic             txd
);
  localparam int FRAME = NBITS + 2;
  localparam int BW    = $clog2(FRAME);
  localparam int TW    = $clog2(OVS);
  localparam logic [TW-1:0] T_LAST = TW'(OVS - 1);
  localparam logic [BW-1:0] B_LAST = BW'(FRAME - 1);

  logic [FRAME-1:0] sr;
  logic [BW-1:0]    bitn;
  logic [TW-1:0]    tcnt;
  logic             busy_q;
  logic             txd_q;

  assign load = req & ~busy_q & ~clr;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sr     <= '1;
      bitn   <= '0;
      tcnt   <= '0;
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
    end else if (load) begin
      sr     <= {1'b1, din, 1'b0};
      bitn   <= '0;
      tcnt   <= '0;
      busy_q <= 1'b1;
      txd_q  <= 1'b0;
    end else if (busy_q && tick) begin
      if (tcnt == T_LAST) begin
        tcnt <= '0;
        if (bitn == B_LAST) begin
          busy_q <= 1'b0;
          txd_q  <= 1'b1;
        end else begin
          bitn  <= bitn + 1'b1;
          sr    <= {1'b1, sr[FRAME-1:1]};
          txd_q <= sr[1];
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign txd  = txd_q;
endmodule

// File: rtl/sp_rx.sv
module sp_rx import sp_pkg::*; #(
  parameter int NBITS = 8,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             rxd,
  output logic             done,
  output logic [NBITS-1:0] data
);
  localparam int TW = $clog2(OVS);
  localparam int BW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(OVS - 1);
  localparam logic [TW-1:0] T_MID  = TW'(OVS / 2 - 1);
  localparam logic [BW-1:0] B_LAST = BW'(NBITS - 1);

  logic [1:0]       sync;
  logic             rs;
  sp_rx_st_e        st;
  logic [TW-1:0]    tcnt;
  logic [BW-1:0]    bitn;
  logic [NBITS-1:0] shreg;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 2'b11;
    else sync <= {sync[0], rxd};
  end
  assign rs = sync[1];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      st     <= RX_IDLE;
      tcnt   <= '0;
      bitn   <= '0;
      shreg  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick) begin
        unique case (st)
          RX_IDLE: begin
            tcnt <= '0;
            if (!rs) st <= RX_START;
          end
          RX_START: begin
            if (tcnt == T_MID) begin
              tcnt <= '0;
              bitn <= '0;
              st   <= rs ? RX_IDLE : RX_DATA;
            end else tcnt <= tcnt + 1'b1;
          end
          RX_DATA: begin
            if (tcnt == T_LAST) begin
              tcnt  <= '0;
              shreg <= {rs, shreg[NBITS-1:1]};
              if (bitn == B_LAST) st <= RX_STOP;
              else bitn <= bitn + 1'b1;
            end else tcnt <= tcnt + 1'b1;
          end
          RX_STOP: begin
            if (tcnt == T_LAST) begin
              tcnt   <= '0;
              done_q <= 1'b1;
              st     <= RX_IDLE;
            end else tcnt <= tcnt + 1'b1;
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  assign done = done_q;
  assign data = shreg;
endmodule

// File: rtl/serial_port_ctrl.sv
module serial_port_ctrl import sp_pkg::*; #(
  parameter int CLK_DIV = 8,
  parameter int OVS     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_en,
  input  logic               acc_wr,
  input  logic               acc_addr,
  input  logic [SP_BYTE-1:0] acc_wdata,
  output logic [SP_BYTE-1:0] acc_rdata,
  input  logic               rxd,
  output logic               txd,
  output logic               irq
);
  logic               tick;
  logic               rx_done;
  logic [SP_BYTE-1:0] rx_char;
  logic               tx_load;
  logic               tx_busy;

  logic ctrl_wr, mreset, data_wr, data_rd;
  logic rie, tie, ovr_flag, rx_full, tx_full;
  logic [SP_BYTE-1:0] rx_buf, tx_buf, status;
  logic wdata_unused;

  assign ctrl_wr = acc_en &  acc_wr & ~acc_addr;
  assign mreset  = ctrl_wr & (acc_wdata[1:0] == CT_MRESET);
  assign data_wr = acc_en &  acc_wr &  acc_addr;
  assign data_rd = acc_en & ~acc_wr &  acc_addr;
  assign wdata_unused = ^acc_wdata[4:2];

  sp_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  sp_rx #(.NBITS(SP_BYTE), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(mreset), .tick(tick),
    .rxd(rxd), .done(rx_done), .data(rx_char)
  );

  sp_tx #(.NBITS(SP_BYTE), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(mreset), .tick(tick),
    .req(tx_full), .din(tx_buf), .load(tx_load), .busy(tx_busy), .txd(txd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || mreset) begin
      rie      <= 1'b0;
      tie      <= 1'b0;
      ovr_flag <= 1'b0;
      rx_full  <= 1'b0;
      rx_buf   <= '0;
      tx_full  <= 1'b0;
      tx_buf   <= '0;
    end else begin
      if (ctrl_wr) begin
        rie <= acc_wdata[CT_RIE];
        tie <= (acc_wdata[6:5] == CT_TXI_ON);
      end
      if (data_wr) begin
        tx_buf  <= acc_wdata;
        tx_full <= 1'b1;
      end else if (tx_load) begin
        tx_full <= 1'b0;
      end
      if (rx_done) begin
        rx_buf   <= rx_char;
        rx_full  <= 1'b1;
        ovr_flag <= data_rd ? 1'b0 : (ovr_flag | rx_full);
      end else if (data_rd) begin
        rx_full  <= 1'b0;
        ovr_flag <= 1'b0;
      end
    end
  end

  // modem lines are not implemented and read as inactive
  assign irq = (rie & (rx_full | ovr_flag)) | (tie & ~tx_full);

  always_comb begin
    status         = '0;
    status[ST_RXF] = rx_full;
    status[ST_TXE] = ~tx_full;
    status[ST_DCD] = 1'b0;
    status[ST_CTS] = 1'b0;
    status[ST_OVR] = ovr_flag;
    status[ST_IRQ] = irq;
  end

  assign acc_rdata = acc_addr ? rx_buf : status;
endmodule

// File: rtl/serial_port_ctrl_chk.sv
module serial_port_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_en,
  input logic       acc_wr,
  input logic       acc_addr,
  input logic [1:0] wr_code,
  input logic       st_irq_bit,
  input logic       txd,
  input logic       irq,
  input logic       rx_full,
  input logic       ovr_flag,
  input logic       rx_done,
  input logic       tx_busy
);
  // R9: master reset code quiets the port in the next cycle
  a_r9_mreset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && !acc_addr && wr_code == 2'b11)
      |=> (!irq && txd && !rx_full && !ovr_flag));

  // R8: status bit 7 follows the interrupt output
  a_r8_status_irq_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && !acc_addr) |-> (st_irq_bit == irq));

  // R6: overrun can only be pending alongside a held character
  a_r6_ovr_implies_full: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag |-> rx_full);

  // R5: a data read with no new character empties the receive register
  a_r5_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_addr && !rx_done) |=> !rx_full);

  // R2: line idles high whenever no frame is being shifted
  a_r2_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
endmodule

bind serial_port_ctrl serial_port_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
  .acc_addr(acc_addr), .wr_code(acc_wdata[1:0]), .st_irq_bit(acc_rdata[7]),
  .txd(txd), .irq(irq), .rx_full(rx_full), .ovr_flag(ovr_flag),
  .rx_done(rx_done), .tx_busy(tx_busy)
);

// File: tb/sim_serial_port_ctrl.sv
`timescale 1ns/1ps
module sim_serial_port_ctrl;
  localparam int DIV  = 2;
  localparam int OVS  = 16;
  localparam int BITC = DIV * OVS;
  localparam int HALF = BITC / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_en = 1'b0, acc_wr = 1'b0, acc_addr = 1'b0;
  logic [7:0] acc_wdata = 8'h00;
  logic [7:0] acc_rdata;
  logic rxd = 1'b1;
  logic txd, irq;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  // behavioural reference state
  bit m_rie = 0, m_tie = 0, m_rxf = 0, m_ovr = 0, m_txe = 1;
  bit chk_on = 0;

  always #10 clk = ~clk;

  serial_port_ctrl #(.CLK_DIV(DIV), .OVS(OVS)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .rxd(rxd), .txd(txd), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // per-clock comparison of the interrupt line against the model (R8)
  always @(posedge clk) begin
    #5;
    if (rst_n && chk_on && !finished) begin
      n_tests++;
      if (irq !== ((m_rie & (m_rxf | m_ovr)) | (m_tie & m_txe))) begin
        n_fail++;
        $display("FAIL R8 per-clock irq: actual %0b expected %0b at %0t", irq,
                 (m_rie & (m_rxf | m_ovr)) | (m_tie & m_txe), $time);
      end
    end
  end

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_addr = a; acc_wdata = d;
    if (!a) begin
      if (d[1:0] == 2'b11) begin
        m_rie = 0; m_tie = 0; m_ovr = 0; m_rxf = 0; m_txe = 1;
      end else begin
        m_rie = d[7]; m_tie = (d[6:5] == 2'b01);
      end
    end
    @(negedge clk);
    acc_en = 0; acc_wr = 0;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    acc_en = 1; acc_wr = 0; acc_addr = a;
    #2 d = acc_rdata;
    if (a) begin m_rxf = 0; m_ovr = 0; end
    @(negedge clk);
    acc_en = 0;
  endtask

  task automatic send_frame(input logic [7:0] b);
    chk_on = 0;
    @(negedge clk);
    rxd = 0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BITC) @(negedge clk);
    end
    rxd = 1;
    repeat (BITC + 8) @(negedge clk);
    if (m_rxf) m_ovr = 1;
    m_rxf = 1;
    chk_on = 1;
  endtask

  task automatic capture_tx(output logic [7:0] d, output logic st, output logic sp);
    @(negedge txd);
    repeat (HALF) @(negedge clk);
    st = txd;
    for (int i = 0; i < 8; i++) begin
      repeat (BITC) @(negedge clk);
      d[i] = txd;
    end
    repeat (BITC) @(negedge clk);
    sp = txd;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d, d2;
    logic st, sp, st2, sp2;
    int lows;

    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    bus_rd(0, s);
    chk("R1 status after reset", s, 8'h02);
    chk("R1 txd idle", {7'd0, txd}, 8'h01);
    chk("R1 irq low", {7'd0, irq}, 8'h00);
    chk_on = 1;

    // R2 single frame, R3 register empties after load
    fork
      capture_tx(d, st, sp);
      bus_wr(1, 8'hA5);
    join
    chk("R2 start bit", {7'd0, st}, 8'h00);
    chk("R2 data LSB first", d, 8'hA5);
    chk("R2 stop bit", {7'd0, sp}, 8'h01);
    bus_rd(0, s);
    chk("R3 tx register empty again", s, 8'h02);

    // R5 receive
    send_frame(8'h3C);
    bus_rd(0, s);
    chk("R5 rx full status", s, 8'h03);
    bus_rd(1, d);
    chk("R5 rx data", d, 8'h3C);
    bus_rd(0, s);
    chk("R5 rx empty after read", s, 8'h02);

    // R6 overrun
    send_frame(8'h11);
    send_frame(8'h22);
    bus_rd(0, s);
    chk("R6 overrun status", s, 8'h23);
    bus_rd(1, d);
    chk("R6 newest character kept", d, 8'h22);
    bus_rd(0, s);
    chk("R6 overrun cleared by read", s, 8'h02);

    // R8 receive interrupt
    bus_wr(0, 8'h80);
    chk("R7 rie alone no irq", {7'd0, irq}, 8'h00);
    send_frame(8'h5A);
    chk("R8 rx irq high", {7'd0, irq}, 8'h01);
    bus_rd(0, s);
    chk("R8 status bit7 mirrors irq", s, 8'h83);
    bus_rd(1, d);
    chk("R8 rx irq cleared by read", {7'd0, irq}, 8'h00);

    // R7 transmit interrupt enable decoding
    bus_wr(0, 8'h20);
    chk("R7 tie=01 raises irq", {7'd0, irq}, 8'h01);
    bus_wr(0, 8'h40);
    chk("R7 bits 10 disable", {7'd0, irq}, 8'h00);
    bus_wr(0, 8'h60);
    chk("R7 bits 11 disable", {7'd0, irq}, 8'h00);

    // R3 back-to-back bytes
    fork
      begin capture_tx(d, st, sp); capture_tx(d2, st2, sp2); end
      begin bus_wr(1, 8'hC3); bus_wr(1, 8'h7E); bus_rd(0, s); end
    join
    chk("R3 second byte waits", s & 8'h02, 8'h00);
    chk("R3 first frame", d, 8'hC3);
    chk("R3 second frame", d2, 8'h7E);
    chk("R2 second frame framing", {6'd0, st2, sp2}, 8'h01);
    bus_rd(0, s);
    chk("R3 register empty after both", s, 8'h02);

    // R9 master reset with pending data and interrupt
    bus_wr(0, 8'h80);
    send_frame(8'h99);
    send_frame(8'h77);
    chk("R6 irq via overrun", {7'd0, irq}, 8'h01);
    bus_wr(0, 8'h03);
    chk("R9 irq low after reset", {7'd0, irq}, 8'h00);
    bus_rd(0, s);
    chk("R9 status after reset", s, 8'h02);
    bus_rd(1, d);
    chk("R9 rx data emptied", d, 8'h00);

    // R9 reset mid-frame
    chk_on = 0;
    bus_wr(1, 8'h00);
    repeat (60) @(negedge clk);
    chk("R2 line low mid-frame", {7'd0, txd}, 8'h00);
    bus_wr(0, 8'h03);
    chk("R9 txd high after reset", {7'd0, txd}, 8'h01);
    lows = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!txd) lows++;
    end
    chk("R9 frame abandoned", lows[7:0], 8'h00);
    fork
      capture_tx(d, st, sp);
      bus_wr(1, 8'h81);
    join
    chk("R2 frame after reset", {st, sp, 6'd0} ^ d, {1'b0, 1'b1, 6'd0} ^ 8'h81);
    chk_on = 1;

    // R4 short glitch ignored
    chk_on = 0;
    @(negedge clk);
    rxd = 0;
    repeat (4) @(negedge clk);
    rxd = 1;
    repeat (400) @(negedge clk);
    chk_on = 1;
    bus_rd(0, s);
    chk("R4 glitch ignored", s, 8'h02);
    send_frame(8'hE1);
    bus_rd(1, d);
    chk("R4 valid frame after glitch", d, 8'hE1);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule